// File: doc/BRIEF.md
# Banked Memory Address Generator

This block produces the 24-bit memory address for an 8-bit processor whose address space is extended by bank registers. A code fetch takes the 16-bit program counter. While the counter's top bit is set, the active code bank takes the place of that bit and everything above it. The code bank is held in two stages. Software loads a pending bank, and the pending value moves into the active bank only when a branch is taken. One branch can therefore land anywhere in the 23-bit code space.

For data accesses the block builds the address from the pointer registers, the bank registers and the instruction immediate. The addressing-mode select decides which ones are used. Each request starts a four-clock bus access. The address is captured when the request is accepted and does not change until the access ends. The internal address is 24 bits wide, and the low 21 bits of it drive the external bus.

Decoding, register writes other than the pending code bank, and the ALU belong to other blocks. This block receives their register values as inputs.

Top module: `bank_addr_gen`

## Requirements
- R1: With mode code 0 (code fetch) and pc bit 15 clear, the captured address is {8'h00, pc}.
- R2: With mode code 0 and pc bit 15 set, the captured address is {active bank, pc[14:0]}. The active bank is the value it had at the clock edge that accepts the request.
- R3: A write to the pending bank (u_wr) leaves the active bank unchanged. Each clock edge with branch_taken high copies the pending bank into the active bank. If branch_taken and u_wr arrive in the same cycle, the active bank takes the old pending value and the pending bank takes the written value.
- R4: Mode code 1 gives {reg_xi, reg_x} and mode code 2 gives {reg_yi, reg_y}.
- R5: Mode code 3 gives {reg_i, reg_hl} and mode code 4 gives {reg_i, imm16}.
- R6: Mode code 5 gives {reg_i, reg_n, imm8}. For example, reg_n=8'h20, reg_i=8'h00 and imm8=8'h8A give 24'h00208A.
- R7: ext_addr always equals mem_addr[20:0].
- R8: An accepted request occupies exactly four busy cycles, with phase 0, 1, 2, 3 in that order. mem_addr stays constant from phase 0 through phase 3, even if the register or mode inputs change.
- R9: done is high only in phase 3, for one cycle. A request is accepted only while busy is low, so a request held high through an access starts the next access one cycle after done.
- R10: While rst_n is low at a clock edge, the block resets: busy, done and phase go to 0, mem_addr goes to 0, and both code bank stages go to 8'h00.
- R11: The unused mode codes 6 and 7 give a captured address of 24'h000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Access request, accepted while idle |
| mode | input | 3 | Addressing-mode code (0 to 5 used) |
| pc | input | 16 | Program counter |
| branch_taken | input | 1 | Branch strobe; copies pending bank to active bank |
| u_wr | input | 1 | Pending code bank write enable |
| u_wdata | input | 8 | Pending code bank write value |
| reg_i | input | 8 | Data bank register |
| reg_n | input | 8 | Middle-byte register for the short indexed mode |
| reg_xi | input | 8 | Bank of the X pointer |
| reg_x | input | 16 | X pointer |
| reg_yi | input | 8 | Bank of the Y pointer |
| reg_y | input | 16 | Y pointer |
| reg_hl | input | 16 | HL pair |
| imm16 | input | 16 | 16-bit immediate |
| imm8 | input | 8 | 8-bit immediate |
| mem_addr | output | 24 | Captured internal address |
| ext_addr | output | 21 | External address bus |
| phase | output | 2 | Access phase, 0 while idle |
| busy | output | 1 | Access in progress |
| done | output | 1 | Last phase of an access |

## Verification
The bench uses the default parameters: 8-bit banks, 16-bit offsets, 21 external address bits and four phases. With these values the top address bits can be set to all ones. This shows that the external bus drops bits 23 to 21 and keeps bit 20. The phase counter also wraps at its natural 2-bit limit. A request held high and register changes made during an access can both be applied at any phase boundary. This checks that nothing gets into the address while it is being held.

// File: rtl/bag_pkg.sv
// Shared definitions for the banked address generator.
// Assumes the mode field is three bits wide; codes 6 and 7 are unused.
package bag_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        AM_CODE = 3'd0,
        AM_XPTR = 3'd1,
        AM_YPTR = 3'd2,
        AM_HL   = 3'd3,
        AM_IABS = 3'd4,
        AM_NIDX = 3'd5
    } amode_t;
endpackage

// File: rtl/bag_code_bank.sv
// Two-stage code bank register: a pending stage written by software and an
// active stage that follows the pending stage only on a taken branch.
// Assumes branch_taken is a single-cycle strobe from the branch unit.
module bag_code_bank #(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              branch_taken,
    input  logic              u_wr,
    input  logic [BANK_W-1:0] u_wdata,
    output logic [BANK_W-1:0] pend_q,
    output logic [BANK_W-1:0] act_q
);
    // Pending stage: takes software writes only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else if (u_wr)
            pend_q <= u_wdata;
    end

    // Active stage: loads the old pending value on a branch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_q <= '0;
        else if (branch_taken)
            act_q <= pend_q;
    end

    AST_ACT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !branch_taken |=> $stable(act_q)); // R3
    AST_ACT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        branch_taken |=> act_q == $past(pend_q)); // R3
endmodule

// File: rtl/bag_addr_former.sv
// Combinational address former: selects bank and offset sources by mode.
// Assumes the offset is twice the bank width, so the short indexed mode
// splits the offset into a middle register byte and an immediate low byte.
module bag_addr_former
    import bag_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int OFFS_W = 16,
    localparam int ADDR_W = BANK_W + OFFS_W,
    localparam int LOW_W  = OFFS_W - BANK_W
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [OFFS_W-1:0] pc,
    input  logic [BANK_W-1:0] code_bank,
    input  logic [BANK_W-1:0] reg_i,
    input  logic [BANK_W-1:0] reg_n,
    input  logic [BANK_W-1:0] reg_xi,
    input  logic [OFFS_W-1:0] reg_x,
    input  logic [BANK_W-1:0] reg_yi,
    input  logic [OFFS_W-1:0] reg_y,
    input  logic [OFFS_W-1:0] reg_hl,
    input  logic [OFFS_W-1:0] imm16,
    input  logic [LOW_W-1:0]  imm8,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] fetch_addr;

    // Fetch address: banked when the counter's top bit is set.
    always_comb begin
        if (pc[OFFS_W-1])
            fetch_addr = {1'b0, code_bank, pc[OFFS_W-2:0]};
        else
            fetch_addr = {{BANK_W{1'b0}}, pc};
    end

    // Mode select: pick bank and offset for the requested access.
    always_comb begin
        case (mode)
            AM_CODE: addr = fetch_addr;
            AM_XPTR: addr = {reg_xi, reg_x};
            AM_YPTR: addr = {reg_yi, reg_y};
            AM_HL:   addr = {reg_i, reg_hl};
            AM_IABS: addr = {reg_i, imm16};
            AM_NIDX: addr = {reg_i, reg_n, imm8};
            default: addr = '0;
        endcase
    end

    always_comb begin
        if (mode == AM_CODE && !pc[OFFS_W-1])
            AST_FETCH_LOW: assert (addr[ADDR_W-1:OFFS_W] == '0); // R1
    end
endmodule

// File: rtl/bag_bus_seq.sv
// Bus access sequencer: accepts a request while idle, captures the address,
// then steps through a fixed number of phases and flags the last one.
// Assumes the requester holds off or repeats requests until busy is low.
module bag_bus_seq #(
    parameter int ADDR_W = 24,
    parameter int PHASES = 4,
    localparam int PH_W  = (PHASES > 1) ? $clog2(PHASES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [PH_W-1:0]   phase,
    output logic              busy,
    output logic              done
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

    logic accept;

    // Acceptance: only an idle sequencer takes a request.
    always_comb accept = req && !busy;

    // Busy flag and phase counter for the access in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            phase <= '0;
        end else if (busy) begin
            if (phase == LAST_PH) begin
                busy  <= 1'b0;
                phase <= '0;
            end else begin
                phase <= phase + 1'b1;
            end
        end else if (accept) begin
            busy  <= 1'b1;
            phase <= '0;
        end
    end

    // Address capture on acceptance; held for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (accept)
            addr_q <= addr_in;
    end

    // Completion flag during the last phase.
    always_comb done = busy && (phase == LAST_PH);

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && phase != '0 |-> $stable(addr_q)); // R8
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy && phase != LAST_PH |=> busy && phase == $past(phase) + 1'b1); // R8
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R9
    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy); // R9
    AST_START_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> phase == '0); // R8
endmodule

// File: rtl/bank_addr_gen.sv
// Banked memory address generator top: joins the two-stage code bank, the
// mode-driven address former and the four-phase bus sequencer, and trims the
// captured address to the external bus width.
// Assumes register values come from the register file and are valid when
// req is sampled.
module bank_addr_gen
    import bag_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int OFFS_W = 16,
    parameter int EXT_W  = 21,
    parameter int PHASES = 4,
    localparam int ADDR_W = BANK_W + OFFS_W,
    localparam int LOW_W  = OFFS_W - BANK_W,
    localparam int PH_W   = (PHASES > 1) ? $clog2(PHASES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [MODE_W-1:0] mode,
    input  logic [OFFS_W-1:0] pc,
    input  logic              branch_taken,
    input  logic              u_wr,
    input  logic [BANK_W-1:0] u_wdata,
    input  logic [BANK_W-1:0] reg_i,
    input  logic [BANK_W-1:0] reg_n,
    input  logic [BANK_W-1:0] reg_xi,
    input  logic [OFFS_W-1:0] reg_x,
    input  logic [BANK_W-1:0] reg_yi,
    input  logic [OFFS_W-1:0] reg_y,
    input  logic [OFFS_W-1:0] reg_hl,
    input  logic [OFFS_W-1:0] imm16,
    input  logic [LOW_W-1:0]  imm8,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [EXT_W-1:0]  ext_addr,
    output logic [PH_W-1:0]   phase,
    output logic              busy,
    output logic              done
);
    logic [BANK_W-1:0] pend_bank;
    logic [BANK_W-1:0] act_bank;
    logic [ADDR_W-1:0] formed;

    bag_code_bank #(.BANK_W(BANK_W)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .branch_taken (branch_taken),
        .u_wr         (u_wr),
        .u_wdata      (u_wdata),
        .pend_q       (pend_bank),
        .act_q        (act_bank)
    );

    bag_addr_former #(.BANK_W(BANK_W), .OFFS_W(OFFS_W)) u_form (
        .mode      (mode),
        .pc        (pc),
        .code_bank (act_bank),
        .reg_i     (reg_i),
        .reg_n     (reg_n),
        .reg_xi    (reg_xi),
        .reg_x     (reg_x),
        .reg_yi    (reg_yi),
        .reg_y     (reg_y),
        .reg_hl    (reg_hl),
        .imm16     (imm16),
        .imm8      (imm8),
        .addr      (formed)
    );

    bag_bus_seq #(.ADDR_W(ADDR_W), .PHASES(PHASES)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .addr_in (formed),
        .addr_q  (mem_addr),
        .phase   (phase),
        .busy    (busy),
        .done    (done)
    );

    // External bus: low bits of the captured address only.
    always_comb ext_addr = mem_addr[EXT_W-1:0];

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !busy && !done && mem_addr == '0); // R10
    AST_ACCEPT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        req && !busy |=> busy && mem_addr == $past(formed)); // R8
endmodule

// File: tb/test_bank_addr_gen.sv
// Cycle-by-cycle bench: a behavioural model of banks, sequencer and address
// is advanced on every rising edge and compared a quarter period later.
module test_bank_addr_gen;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [15:0] pc = 16'h0;
    logic        branch_taken = 1'b0;
    logic        u_wr = 1'b0;
    logic [7:0]  u_wdata = 8'h0;
    logic [7:0]  reg_i = 8'h0, reg_n = 8'h0, reg_xi = 8'h0, reg_yi = 8'h0;
    logic [15:0] reg_x = 16'h0, reg_y = 16'h0, reg_hl = 16'h0, imm16 = 16'h0;
    logic [7:0]  imm8 = 8'h0;
    logic [23:0] mem_addr;
    logic [20:0] ext_addr;
    logic [1:0]  phase;
    logic        busy, done;

    bank_addr_gen i_bank_addr_gen (
        .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .pc(pc),
        .branch_taken(branch_taken), .u_wr(u_wr), .u_wdata(u_wdata),
        .reg_i(reg_i), .reg_n(reg_n), .reg_xi(reg_xi), .reg_x(reg_x),
        .reg_yi(reg_yi), .reg_y(reg_y), .reg_hl(reg_hl), .imm16(imm16),
        .imm8(imm8), .mem_addr(mem_addr), .ext_addr(ext_addr),
        .phase(phase), .busy(busy), .done(done)
    );

    always #(CLK_P/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string tag = "R10";

    // Behavioural model state.
    int m_u = 0, m_v = 0, m_busy = 0, m_ph = 0;
    longint m_addr = 0;

    function automatic longint model_addr();
        longint a;
        case (mode)
            3'd0: a = pc[15] ? (longint'(m_v) * 32768 + (pc & 16'h7FFF)) : longint'(pc);
            3'd1: a = longint'(reg_xi) * 65536 + reg_x;
            3'd2: a = longint'(reg_yi) * 65536 + reg_y;
            3'd3: a = longint'(reg_i) * 65536 + reg_hl;
            3'd4: a = longint'(reg_i) * 65536 + imm16;
            3'd5: a = longint'(reg_i) * 65536 + longint'(reg_n) * 256 + imm8;
            default: a = 0;
        endcase
        return a;
    endfunction

    task automatic check(input string req_tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req_tag, act, exp, cycles);
        end
    endtask

    // Model step and delayed comparison on every clock.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_u = 0; m_v = 0; m_busy = 0; m_ph = 0; m_addr = 0;
        end else begin
            longint f;
            f = model_addr();
            if (m_busy != 0) begin
                if (m_ph == 3) begin m_busy = 0; m_ph = 0; end
                else m_ph++;
            end else if (req) begin
                m_busy = 1; m_ph = 0; m_addr = f;
            end
            if (branch_taken) m_v = m_u;
            if (u_wr) m_u = u_wdata;
        end
        #(CLK_P/4);
        check(tag, mem_addr, m_addr);
        check("R7", ext_addr, m_addr % (64'd1 << 21));
        check("R8", phase, m_ph);
        check("R8", busy, m_busy);
        check("R9", done, (m_busy != 0 && m_ph == 3) ? 1 : 0);
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_P * 20000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // One access: request for one cycle, then wait until idle again.
    task automatic access(input string t);
        tag = t;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10", {busy, done, phase}, 0);
        check("R10", mem_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: unbanked fetch
        mode = 3'd0; pc = 16'h1234;
        access("R1");
        check("R1", mem_addr, 24'h001234);

        // R3: pending write alone leaves the active bank at reset value
        u_wr = 1'b1; u_wdata = 8'h5A;
        @(negedge clk);
        u_wr = 1'b0;
        pc = 16'h8123;
        access("R3");
        check("R3", mem_addr, 24'h000123);

        // R2: branch moves the pending bank into the active bank
        branch_taken = 1'b1;
        @(negedge clk);
        branch_taken = 1'b0;
        pc = 16'hF00F;
        access("R2");
        check("R2", mem_addr, 24'h2D700F);

        // R3: branch and write in the same cycle
        branch_taken = 1'b1; u_wr = 1'b1; u_wdata = 8'h77;
        @(negedge clk);
        branch_taken = 1'b0; u_wr = 1'b0;
        access("R3");
        check("R3", mem_addr, 24'h2D700F);
        branch_taken = 1'b1;
        @(negedge clk);
        branch_taken = 1'b0;
        pc = 16'hFFFF;
        access("R3");
        check("R3", mem_addr, 24'h3BFFFF);

        // R4 and R7: pointer modes, with all-ones upper bits
        reg_xi = 8'hFF; reg_x = 16'hFFFF; reg_yi = 8'h12; reg_y = 16'hABCD;
        mode = 3'd1;
        access("R4");
        check("R7", ext_addr, 21'h1FFFFF);
        mode = 3'd2;
        access("R4");
        check("R4", mem_addr, 24'h12ABCD);

        // R5: bank I with HL and with a 16-bit immediate
        reg_i = 8'h04; reg_hl = 16'h5566; imm16 = 16'h9AB0;
        mode = 3'd3;
        access("R5");
        check("R5", mem_addr, 24'h045566);
        mode = 3'd4;
        access("R5");
        check("R5", mem_addr, 24'h049AB0);

        // R6: short indexed mode example
        reg_i = 8'h00; reg_n = 8'h20; imm8 = 8'h8A;
        mode = 3'd5;
        access("R6");
        check("R6", mem_addr, 24'h00208A);

        // R11: unused mode codes give zero
        mode = 3'd6;
        access("R11");
        check("R11", mem_addr, 0);
        mode = 3'd7;
        access("R11");
        check("R11", mem_addr, 0);

        // R8 and R9: request held high, inputs changing mid-access
        tag = "R8";
        mode = 3'd1;
        req = 1'b1;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            reg_x = reg_x + 16'h0111;
            mode = (k % 2 == 0) ? 3'd2 : 3'd1;
        end
        req = 1'b0;
        repeat (6) @(negedge clk);

        // R10: reset in the middle of an access
        tag = "R10";
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", {busy, done, phase}, 0);
        rst_n = 1'b1;
        mode = 3'd0; pc = 16'h8001;
        access("R10");
        check("R10", mem_addr, 24'h000001);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule